// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps the flags that tell firmware why a small processor core last restarted or woke. Each cycle it looks at a set of one-cycle cause pulses: power-on, brown-out, the software reset instruction, the external clear pin, watchdog expiry, stack overflow, stack underflow and interrupt wake-up. Only the highest-priority pulse takes effect. That cause then sets, clears or leaves alone each flag according to its own rule. The block also decides whether the event is a true reset or a wake-up, and it gives the address the core restarts from.

A small state machine drives the request outputs. It has three states. ST_RUN is the quiet state. ST_RESET drives `reset_req` and ST_WAKE drives `wake_req`. The transitions are:

- RUN_TO_RESET or WAKE_TO_RESET or RESET_TO_RESET: taken when the winning cause is a true reset.
- ANY_TO_WAKE: taken when the winning cause is a wake-up.
- BACK_TO_RUN: taken when there is no pulse, or when the pulse is a stack event that does not reset.

Firmware can set the five reset flags again through a write port that sets only the bits written as 1. A later event of the same kind then shows up as a cleared flag.

Top module: `rcs_status`

## Requirements

- R1: While `rst_n` is low, and just after it is released, the outputs read as follows. `status` is 8'h00, `reset_req` and `wake_req` are 0, and `next_pc` is 0. The fields of `status` are: bit0 swr (software-reset flag), bit1 tmo (timeout flag), bit2 pdn (power-down flag), bit3 pon (power-on flag), bit4 brn (brown-out flag), bit5 sovf (stack overflow), bit6 sunf (stack underflow), bit7 sbe (software brown-out enable).
- R2: A power-on pulse has these effects:
  - It sets swr, tmo and pdn to 1.
  - It clears pon, brn, sovf and sunf to 0.
  - It sets sbe to 1 exactly when `bor_cfg` is 2'b01.
  - It is a reset to address 0.
- R3: A brown-out pulse has these effects:
  - It sets swr, tmo and pdn to 1.
  - It clears brn.
  - It keeps pon, sovf and sunf.
  - It is a reset to address 0.
- R4: An external clear is always a reset to address 0. Its effect on the flags depends on `pwr_mode` (2'b00 full power, 2'b01 managed run, 2'b10 idle, 2'b11 sleep):
  - In full power it changes no flag.
  - In managed run it sets tmo.
  - In idle or sleep it sets tmo and clears pdn.
- R5: A watchdog pulse always clears tmo. Its other effects depend on the mode:
  - In full power or managed run it is a reset to address 0.
  - In idle or sleep it also clears pdn. It is then a wake-up with `next_pc` equal to `cur_pc` + 2, wrapping at the PC width.
- R6: An interrupt wake-up clears pdn and is a wake-up. The restart address is chosen as follows:
  - 12'h008 when `hi_gie` is 1.
  - Otherwise 12'h018 when `lo_gie` is 1.
  - Otherwise `cur_pc` + 2.
- R7: A stack overflow sets sovf, and a stack underflow sets sunf. Either one is a reset to address 0 only when `stk_rst_en` is 1. With the enable at 0, no request pulses.
- R8: The software reset instruction clears swr, keeps the other reset flags, and is a reset to address 0.
- R9: On every true reset other than power-on, sbe handles as follows:
  - It keeps its value when `bor_cfg` is 2'b01.
  - Otherwise it goes to 0.
  - Wake-ups and stack events that do not reset leave it alone.
- R10: When pulses arrive in the same cycle, only one takes effect. From highest to lowest priority: power-on, brown-out, external clear, watchdog, stack overflow, stack underflow, reset instruction, interrupt wake-up.
- R11: The effects of an event appear one clock after the cycle of the pulse:
  - The flags change on that edge.
  - `reset_req` or `wake_req` is high for exactly that one cycle, and the two are never high together.
  - `next_pc` holds the restart address while the request is high.
- R12: A write with `wr_en` high in a cycle with no event pulse sets each of bits 4..0 whose `wr_data` bit is 1. It never changes bits 7..5. A write in the same cycle as any event pulse is dropped.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low flop reset |
| ev_por | input | 1 | Power-on pulse |
| ev_bor | input | 1 | Brown-out pulse |
| ev_xclr | input | 1 | External clear pulse |
| ev_wdt | input | 1 | Watchdog expiry pulse |
| ev_sovf | input | 1 | Stack overflow pulse |
| ev_sunf | input | 1 | Stack underflow pulse |
| ev_swrst | input | 1 | Reset instruction pulse |
| ev_irq | input | 1 | Interrupt wake-up pulse |
| pwr_mode | input | 2 | Power mode level |
| stk_rst_en | input | 1 | Stack events cause reset |
| bor_cfg | input | 2 | Brown-out configuration field |
| hi_gie | input | 1 | High-priority global interrupt enable |
| lo_gie | input | 1 | Low-priority global interrupt enable |
| cur_pc | input | PC_W | Current program counter |
| wr_en | input | 1 | Flag write strobe |
| wr_data | input | 8 | Write-one-to-set data |
| status | output | 8 | Flag vector |
| reset_req | output | 1 | One-cycle reset request |
| wake_req | output | 1 | One-cycle wake request |
| next_pc | output | PC_W | Restart address |

## Verification

The external clear and the watchdog are each applied in several power modes. Because the flag outcome differs by mode, these runs show whether the mode decode is correct and whether the event is classed as a reset or a wake-up. Interrupt wake-ups are tried with no enable, with each enable alone, and with both enables set, which checks the vector choice and the wrap of PC + 2 at the top of the address range. Several cause pulses are applied together in one cycle, and a write is issued in the same cycle as an event; in both cases the flag that only a lower-priority cause would change is examined, which shows whether the priority order is correct. Stack events are applied with the reset enable both off and on, and the brown-out configuration is changed between resets, which separates the cases where sbe holds its value from those where it is cleared.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
    localparam int FLAG_W   = 8;
    localparam int BCFG_W   = 2;
    localparam logic [BCFG_W-1:0] BCFG_SW = 2'b01;
    localparam logic [FLAG_W-1:0] WR_MASK = 8'b0001_1111;

    typedef enum logic [1:0] {
        PM_FULL  = 2'b00,
        PM_RUN   = 2'b01,
        PM_IDLE  = 2'b10,
        PM_SLEEP = 2'b11
    } pwr_mode_e;

    typedef enum logic [3:0] {
        CA_NONE, CA_POR, CA_BOR, CA_XCLR, CA_WDT,
        CA_SOVF, CA_SUNF, CA_SWR, CA_IRQ
    } cause_e;

    typedef enum logic [1:0] {
        ST_RUN, ST_RESET, ST_WAKE
    } st_e;

    typedef struct packed {
        logic sbe;
        logic sunf;
        logic sovf;
        logic brn;
        logic pon;
        logic pdn;
        logic tmo;
        logic swr;
    } flags_t;
endpackage

// File: rtl/rcs_prio.sv
module rcs_prio
    import rcs_pkg::*;
(
    input  logic   ev_por,
    input  logic   ev_bor,
    input  logic   ev_xclr,
    input  logic   ev_wdt,
    input  logic   ev_sovf,
    input  logic   ev_sunf,
    input  logic   ev_swrst,
    input  logic   ev_irq,
    output cause_e cause
);
    // Fixed priority: highest listed first.
    always_comb begin
        if (ev_por)        cause = CA_POR;
        else if (ev_bor)   cause = CA_BOR;
        else if (ev_xclr)  cause = CA_XCLR;
        else if (ev_wdt)   cause = CA_WDT;
        else if (ev_sovf)  cause = CA_SOVF;
        else if (ev_sunf)  cause = CA_SUNF;
        else if (ev_swrst) cause = CA_SWR;
        else if (ev_irq)   cause = CA_IRQ;
        else               cause = CA_NONE;
    end
endmodule

// File: rtl/rcs_flag_upd.sv
module rcs_flag_upd
    import rcs_pkg::*;
(
    input  cause_e             cause,
    input  logic [1:0]         pwr_mode,
    input  logic               stk_rst_en,
    input  logic [BCFG_W-1:0]  bor_cfg,
    input  flags_t             cur,
    input  logic               wr_en,
    input  logic [FLAG_W-1:0]  wr_data,
    output flags_t             nxt,
    output logic               is_reset,
    output logic               is_wake
);
    logic low_pwr;
    logic sw_bor;

    assign low_pwr = pwr_mode[1];
    assign sw_bor  = (bor_cfg == BCFG_SW);

    always_comb begin
        nxt      = cur;
        is_reset = 1'b0;
        is_wake  = 1'b0;
        unique case (cause)
            CA_POR: begin
                nxt.swr  = 1'b1;
                nxt.tmo  = 1'b1;
                nxt.pdn  = 1'b1;
                nxt.pon  = 1'b0;
                nxt.brn  = 1'b0;
                nxt.sovf = 1'b0;
                nxt.sunf = 1'b0;
                nxt.sbe  = sw_bor;
                is_reset = 1'b1;
            end
            CA_BOR: begin
                nxt.swr  = 1'b1;
                nxt.tmo  = 1'b1;
                nxt.pdn  = 1'b1;
                nxt.brn  = 1'b0;
                is_reset = 1'b1;
            end
            CA_XCLR: begin
                if (pwr_mode != PM_FULL) nxt.tmo = 1'b1;
                if (low_pwr)             nxt.pdn = 1'b0;
                is_reset = 1'b1;
            end
            CA_WDT: begin
                nxt.tmo = 1'b0;
                if (low_pwr) begin
                    nxt.pdn = 1'b0;
                    is_wake = 1'b1;
                end else begin
                    is_reset = 1'b1;
                end
            end
            CA_SOVF: begin
                nxt.sovf = 1'b1;
                is_reset = stk_rst_en;
            end
            CA_SUNF: begin
                nxt.sunf = 1'b1;
                is_reset = stk_rst_en;
            end
            CA_SWR: begin
                nxt.swr  = 1'b0;
                is_reset = 1'b1;
            end
            CA_IRQ: begin
                nxt.pdn = 1'b0;
                is_wake = 1'b1;
            end
            CA_NONE: begin
                if (wr_en) nxt = flags_t'(cur | (wr_data & WR_MASK));
            end
            default: ;
        endcase
        // Non-power-on resets keep sbe only under software brown-out control.
        if (is_reset && cause != CA_POR && !sw_bor) nxt.sbe = 1'b0;
    end
endmodule

// File: rtl/rcs_pc_sel.sv
module rcs_pc_sel
    import rcs_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int VEC_HI = 'h008,
    parameter int VEC_LO = 'h018,
    parameter int STEP   = 2
) (
    input  cause_e            cause,
    input  logic              is_reset,
    input  logic              hi_gie,
    input  logic              lo_gie,
    input  logic [PC_W-1:0]   cur_pc,
    output logic [PC_W-1:0]   tgt_pc
);
    localparam logic [PC_W-1:0] V_HI = PC_W'(VEC_HI);
    localparam logic [PC_W-1:0] V_LO = PC_W'(VEC_LO);
    localparam logic [PC_W-1:0] INC  = PC_W'(STEP);

    always_comb begin
        if (is_reset)                      tgt_pc = '0;
        else if (cause == CA_IRQ && hi_gie) tgt_pc = V_HI;
        else if (cause == CA_IRQ && lo_gie) tgt_pc = V_LO;
        else                               tgt_pc = cur_pc + INC;
    end
endmodule

// File: rtl/rcs_status.sv
module rcs_status
    import rcs_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_por,
    input  logic              ev_bor,
    input  logic              ev_xclr,
    input  logic              ev_wdt,
    input  logic              ev_sovf,
    input  logic              ev_sunf,
    input  logic              ev_swrst,
    input  logic              ev_irq,
    input  logic [1:0]        pwr_mode,
    input  logic              stk_rst_en,
    input  logic [1:0]        bor_cfg,
    input  logic              hi_gie,
    input  logic              lo_gie,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        status,
    output logic              reset_req,
    output logic              wake_req,
    output logic [PC_W-1:0]   next_pc
);
    cause_e          cause;
    flags_t          flg_q, flg_d;
    logic            is_reset, is_wake;
    logic [PC_W-1:0] tgt_pc, pc_q;
    st_e             st_q, st_d;

    rcs_prio u_prio (
        .ev_por   (ev_por),
        .ev_bor   (ev_bor),
        .ev_xclr  (ev_xclr),
        .ev_wdt   (ev_wdt),
        .ev_sovf  (ev_sovf),
        .ev_sunf  (ev_sunf),
        .ev_swrst (ev_swrst),
        .ev_irq   (ev_irq),
        .cause    (cause)
    );

    rcs_flag_upd u_upd (
        .cause      (cause),
        .pwr_mode   (pwr_mode),
        .stk_rst_en (stk_rst_en),
        .bor_cfg    (bor_cfg),
        .cur        (flg_q),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .nxt        (flg_d),
        .is_reset   (is_reset),
        .is_wake    (is_wake)
    );

    rcs_pc_sel #(.PC_W(PC_W)) u_pc (
        .cause    (cause),
        .is_reset (is_reset),
        .hi_gie   (hi_gie),
        .lo_gie   (lo_gie),
        .cur_pc   (cur_pc),
        .tgt_pc   (tgt_pc)
    );

    // Next-state selection.
    always_comb begin
        if (is_reset)     st_d = ST_RESET;
        else if (is_wake) st_d = ST_WAKE;
        else              st_d = ST_RUN;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    // Flag and restart-address registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flg_q <= '0;
            pc_q  <= '0;
        end else begin
            flg_q <= flg_d;
            if (is_reset || is_wake) pc_q <= tgt_pc;
        end
    end

    // Outputs decoded from state.
    always_comb begin
        reset_req = 1'b0;
        wake_req  = 1'b0;
        unique case (st_q)
            ST_RUN:   ;
            ST_RESET: reset_req = 1'b1;
            ST_WAKE:  wake_req  = 1'b1;
            default:  ;
        endcase
    end

    assign status  = flg_q;
    assign next_pc = pc_q;
endmodule

// File: rtl/rcs_status_chk.sv
module rcs_status_chk #(
    parameter int PC_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ev_por,
    input logic            ev_bor,
    input logic            ev_xclr,
    input logic            ev_wdt,
    input logic            ev_sovf,
    input logic            ev_sunf,
    input logic            ev_swrst,
    input logic            ev_irq,
    input logic [1:0]      pwr_mode,
    input logic            stk_rst_en,
    input logic            wr_en,
    input logic [PC_W-1:0] cur_pc,
    input logic [7:0]      status,
    input logic            reset_req,
    input logic            wake_req,
    input logic [PC_W-1:0] next_pc
);
    logic any_ev;
    assign any_ev = ev_por | ev_bor | ev_xclr | ev_wdt | ev_sovf |
                    ev_sunf | ev_swrst | ev_irq;

    p_por_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_por |=> reset_req && next_pc == '0 && status[2:0] == 3'b111 &&
                   status[6:3] == 4'b0000);

    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(reset_req && wake_req));

    p_req_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req || wake_req) |-> $past(any_ev));

    p_swr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_swrst && !(ev_por | ev_bor | ev_xclr | ev_wdt | ev_sovf | ev_sunf))
        |=> reset_req && !status[0]);

    p_stk_norst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_sunf && !stk_rst_en &&
         !(ev_por | ev_bor | ev_xclr | ev_wdt | ev_sovf))
        |=> !reset_req && !wake_req && status[6]);

    p_wdt_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wdt && pwr_mode[1] && !(ev_por | ev_bor | ev_xclr))
        |=> wake_req && !status[1] && !status[2] &&
            next_pc == PC_W'($past(cur_pc) + PC_W'(2)));

    p_wr_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !any_ev) |=> status[7:5] == $past(status[7:5]));
endmodule

bind rcs_status rcs_status_chk #(.PC_W(PC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_por     (ev_por),
    .ev_bor     (ev_bor),
    .ev_xclr    (ev_xclr),
    .ev_wdt     (ev_wdt),
    .ev_sovf    (ev_sovf),
    .ev_sunf    (ev_sunf),
    .ev_swrst   (ev_swrst),
    .ev_irq     (ev_irq),
    .pwr_mode   (pwr_mode),
    .stk_rst_en (stk_rst_en),
    .wr_en      (wr_en),
    .cur_pc     (cur_pc),
    .status     (status),
    .reset_req  (reset_req),
    .wake_req   (wake_req),
    .next_pc    (next_pc)
);

// File: tb/tb_rcs_status.sv
`timescale 1ns/1ps
module tb_rcs_status;
    localparam int PC_W = 16;
    // Event vector bit order used by the bench only.
    localparam int E_POR = 0, E_BOR = 1, E_XCLR = 2, E_WDT = 3;
    localparam int E_SOVF = 4, E_SUNF = 5, E_SWR = 6, E_IRQ = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] ev = '0;
    logic [1:0] pwr_mode = 2'b00;
    logic stk_rst_en = 1'b0;
    logic [1:0] bor_cfg = 2'b01;
    logic hi_gie = 1'b0, lo_gie = 1'b0;
    logic [PC_W-1:0] cur_pc = '0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] status;
    logic reset_req, wake_req;
    logic [PC_W-1:0] next_pc;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rcs_status #(.PC_W(PC_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .ev_por(ev[E_POR]), .ev_bor(ev[E_BOR]), .ev_xclr(ev[E_XCLR]),
        .ev_wdt(ev[E_WDT]), .ev_sovf(ev[E_SOVF]), .ev_sunf(ev[E_SUNF]),
        .ev_swrst(ev[E_SWR]), .ev_irq(ev[E_IRQ]),
        .pwr_mode(pwr_mode), .stk_rst_en(stk_rst_en), .bor_cfg(bor_cfg),
        .hi_gie(hi_gie), .lo_gie(lo_gie), .cur_pc(cur_pc),
        .wr_en(wr_en), .wr_data(wr_data),
        .status(status), .reset_req(reset_req), .wake_req(wake_req),
        .next_pc(next_pc)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Check flags, both requests and the restart address in one go.
    task automatic chk_all(input string req, input logic [7:0] st,
                           input logic rr, input logic wr,
                           input logic [PC_W-1:0] pc);
        chk(req, "status", 32'(status), 32'(st));
        chk(req, "reset_req", 32'(reset_req), 32'(rr));
        chk(req, "wake_req", 32'(wake_req), 32'(wr));
        chk(req, "next_pc", 32'(next_pc), 32'(pc));
    endtask

    task automatic fire(input logic [7:0] e);
        @(negedge clk);
        ev = e;
        @(negedge clk);
        ev = '0;
    endtask

    task automatic wr_flags(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        chk_all("R1", 8'h00, 1'b0, 1'b0, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1", 8'h00, 1'b0, 1'b0, '0);
    endtask

    task automatic t_por;
        bor_cfg = 2'b01;
        cur_pc = 16'h0444;
        fire(8'h01 << E_POR);
        chk_all("R2", 8'h87, 1'b1, 1'b0, '0);
        @(negedge clk);
        chk("R11", "reset_req drop", 32'(reset_req), 32'd0);
    endtask

    task automatic t_write;
        wr_flags(8'hFF);
        chk("R12", "w1s low bits only", 32'(status), 32'h9F);
    endtask

    task automatic t_bor;
        fire(8'h01 << E_BOR);
        chk_all("R3", 8'h8F, 1'b1, 1'b0, '0); // R9: sbe kept with cfg 01
    endtask

    task automatic t_swr;
        bor_cfg = 2'b00;
        fire(8'h01 << E_SWR);
        chk_all("R8", 8'h0E, 1'b1, 1'b0, '0); // R9: sbe cleared
    endtask

    task automatic t_wdt_run;
        pwr_mode = 2'b01;
        fire(8'h01 << E_WDT);
        chk_all("R5", 8'h0C, 1'b1, 1'b0, '0);
    endtask

    task automatic t_xclr;
        pwr_mode = 2'b00;
        fire(8'h01 << E_XCLR);
        chk_all("R4", 8'h0C, 1'b1, 1'b0, '0);
        pwr_mode = 2'b01;
        fire(8'h01 << E_XCLR);
        chk_all("R4", 8'h0E, 1'b1, 1'b0, '0);
        pwr_mode = 2'b11;
        fire(8'h01 << E_XCLR);
        chk_all("R4", 8'h0A, 1'b1, 1'b0, '0);
    endtask

    task automatic t_wdt_sleep;
        wr_flags(8'h04);
        chk("R12", "pdn set", 32'(status), 32'h0E);
        pwr_mode = 2'b10;
        cur_pc = 16'h1234;
        fire(8'h01 << E_WDT);
        chk_all("R5", 8'h08, 1'b0, 1'b1, 16'h1236);
        @(negedge clk);
        chk("R11", "wake_req drop", 32'(wake_req), 32'd0);
    endtask

    task automatic t_irq;
        wr_flags(8'h06);
        cur_pc = 16'hFFFF;
        fire(8'h01 << E_IRQ);
        chk_all("R6", 8'h0A, 1'b0, 1'b1, 16'h0001);
        hi_gie = 1'b1;
        fire(8'h01 << E_IRQ);
        chk("R6", "hi vector", 32'(next_pc), 32'h008);
        hi_gie = 1'b0; lo_gie = 1'b1;
        fire(8'h01 << E_IRQ);
        chk("R6", "lo vector", 32'(next_pc), 32'h018);
        hi_gie = 1'b1;
        fire(8'h01 << E_IRQ);
        chk("R6", "both vector", 32'(next_pc), 32'h008);
        hi_gie = 1'b0; lo_gie = 1'b0;
    endtask

    task automatic t_stack;
        cur_pc = 16'h0100;
        stk_rst_en = 1'b0;
        fire(8'h01 << E_SUNF);
        chk("R7", "sunf set", 32'(status), 32'h4A);
        chk("R7", "no reset", 32'(reset_req), 32'd0);
        chk("R7", "no wake", 32'(wake_req), 32'd0);
        stk_rst_en = 1'b1;
        fire(8'h01 << E_SOVF);
        chk_all("R7", 8'h6A, 1'b1, 1'b0, '0);
        wr_flags(8'hE0);
        chk("R12", "bits 7..5 ignore writes", 32'(status), 32'h6A);
    endtask

    task automatic t_prio;
        fire((8'h01 << E_BOR) | (8'h01 << E_XCLR) | (8'h01 << E_SWR));
        chk_all("R10", 8'h6F, 1'b1, 1'b0, '0);
        pwr_mode = 2'b11;
        fire((8'h01 << E_XCLR) | (8'h01 << E_WDT) | (8'h01 << E_IRQ));
        chk_all("R10", 8'h6B, 1'b1, 1'b0, '0);
    endtask

    task automatic t_wr_vs_ev;
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 8'h10;
        ev = 8'h01 << E_SWR;
        @(negedge clk);
        wr_en = 1'b0;
        ev = '0;
        chk("R12", "write dropped on event", 32'(status), 32'h6A);
    endtask

    task automatic t_por_again;
        bor_cfg = 2'b00;
        fire(8'h01 << E_POR);
        chk_all("R2", 8'h07, 1'b1, 1'b0, '0); // R9: cfg not 01 gives sbe 0
    endtask

    initial begin
        #(200_000 * 20);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_por();
        t_write();
        t_bor();
        t_swr();
        t_wdt_run();
        t_xclr();
        t_wdt_sleep();
        t_irq();
        t_stack();
        t_prio();
        t_wr_vs_ev();
        t_por_again();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule